// File: doc/BRIEF.md
# Multi-Word Message Queue Mailbox

A bank of hardware message queues reached over a simple 32-bit register bus. A producer builds a message of sixteen 32-bit words in a per-queue window. The bus address carries a requester field, a queue number and a word index. Writing the highest word index commits the whole message atomically. Until then, the words sit in a staging buffer that no reader can see.

A consumer reads the head message word by word from the same window. Reading the highest word index removes the message, so no separate push or pop register is needed. A status word per queue gives the pending-message count and a sticky overflow flag. One interrupt line per queue stays high while that queue holds at least one message.

Queue count and total message capacity are parameters. Capacity is split evenly, so each queue holds `MSG_TOTAL / NUM_Q` messages. Read data appears on `rdata_o` one clock after the read request and holds until the next read.

Top module: `msgq_mailbox`

## Requirements
- R1: A data access uses address bit 20 = 0, the queue number in bits 15:7 and the word index in bits 6:2. Word indices 16..31 carry message words 0..15. The requester field in bits 19:16 is ignored, so any requester value reaches the same queue. A status access uses bit 20 = 1 with the queue number in bits 15:2.
- R2: Writes to word indices 16..30 only fill the queue's staging buffer. They leave the pending count unchanged, and reads still see the previous head message, or zeros if the queue is empty.
- R3: A write to word index 31 of a queue that is not full appends one message. The message is staging words 0..14 plus the written word as word 15, and the count rises by one.
- R4: A read of word index 16+k returns word k of the head message on `rdata_o` in the cycle after the request. `rdata_o` holds its value on cycles without a read.
- R5: A read of word index 31 of a non-empty queue removes the head message. Reads of indices 16..30 never change the count.
- R6: Each queue returns its messages in commit order. Traffic on one queue does not change another queue's contents, count or interrupt.
- R7: The status word holds the pending count in bits 23:12 and the overflow flag in bit 0. All other bits read as zero.
- R8: `irq_o[q]` is high exactly while queue q holds a message. It drops in the cycle after the read that removes the last message.
- R9: A commit to a queue that already holds `MSG_TOTAL/NUM_Q` messages is discarded and sets that queue's overflow flag. The flag stays set until reset.
- R10: A read of any word of an empty queue returns zero and leaves the count at zero.
- R11: An access whose queue number is `NUM_Q` or above, or whose word index is below 16, changes no state, and a read of it returns zero.
- R12: After reset, all counts, overflow flags, interrupts and `rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 21 | Byte address (region bit, requester, queue, word index) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NUM_Q | Per-queue receive interrupt, high while messages are pending |

## Verification
Several input patterns exercise the main function, and each separates a different kind of fault:
- A lone partial message separates staging from committing.
- Two messages sent through different requester values and read back through a third show whether the requester field is truly ignored and whether order is first-in, first-out.
- Repeated reads of a middle word show that only the last index pops.
- A third commit into a two-deep queue, followed by reads of the empty queue, covers the overflow flag and the zero-return case.
- Writes to low word indices and to an out-of-range queue, interleaved with a real message, expose any decode aliasing into the staging buffer.
- Two queues pending at once test independence of counts and interrupts.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 16;
  localparam int WIDX_W    = 4;
  localparam int ADDR_W    = 21;
  localparam int STAT_BIT  = 20;
  localparam int CNT_LSB   = 12;
  localparam int CNT_FLD_W = 12;
  localparam int QFLD_W    = 14;
endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
  import msgq_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int QID_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              stat_sel_o,
  output logic              data_sel_o,
  output logic [QID_W-1:0]  qid_o,
  output logic [WIDX_W-1:0] word_o
);
  logic              is_stat;
  logic [QFLD_W-1:0] qfield;
  logic              in_range;
  logic              unused_addr;

  assign is_stat     = addr_i[STAT_BIT];
  assign qfield      = is_stat ? addr_i[15:2] : {5'd0, addr_i[15:7]};
  assign in_range    = 32'(qfield) < NUM_Q;
  assign qid_o       = qfield[QID_W-1:0];
  assign word_o      = addr_i[5:2];
  // word index >= 16 <=> address bit 6
  assign data_sel_o  = !is_stat && addr_i[6] && in_range;
  assign stat_sel_o  = is_stat && in_range;
  assign unused_addr = ^{addr_i[19:16], addr_i[1:0], qfield[QFLD_W-1:QID_W]};
endmodule

// File: rtl/msgq_queue.sv
module msgq_queue
  import msgq_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WIDX_W-1:0] word_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(MSG_WORDS - 1);

  logic [WORD_W-1:0] stage_q [MSG_WORDS-1];
  logic [WORD_W-1:0] mem_q   [DEPTH][MSG_WORDS];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic              commit, full, accept, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign commit = wr_i && (word_i == LAST);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign accept = commit && !full;
  assign pop    = rd_i && (word_i == LAST) && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (wr_i && word_i != LAST) stage_q[word_i] <= wdata_i;
    if (accept) begin
      for (int j = 0; j < MSG_WORDS - 1; j++) mem_q[wptr_q][j] <= stage_q[j];
      mem_q[wptr_q][MSG_WORDS-1] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (accept) begin
        wptr_q <= ptr_inc(wptr_q);
        cnt_q  <= cnt_q + 1'b1;
      end
      if (commit && full) ovf_q <= 1'b1;
      if (pop) begin
        rptr_q <= ptr_inc(rptr_q);
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign rdata_o = (cnt_q != '0) ? mem_q[rptr_q][word_i] : '0;
  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/msgq_mailbox.sv
module msgq_mailbox
  import msgq_pkg::*;
#(
  parameter int NUM_Q     = 4,
  parameter int MSG_TOTAL = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [NUM_Q-1:0]  irq_o
);
  localparam int DEPTH = MSG_TOTAL / NUM_Q;
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              stat_sel, data_sel;
  logic [QID_W-1:0]  qid;
  logic [WIDX_W-1:0] word;
  logic [WORD_W-1:0] q_rdata [NUM_Q];
  logic [CNT_W-1:0]  q_cnt   [NUM_Q];
  logic [NUM_Q-1:0]  ovf_q;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] rdata_q;

  msgq_decode #(.NUM_Q(NUM_Q), .QID_W(QID_W)) dec_i (
    .addr_i     (addr_i),
    .stat_sel_o (stat_sel),
    .data_sel_o (data_sel),
    .qid_o      (qid),
    .word_o     (word)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    logic hit;
    assign hit = req_i && data_sel && (qid == QID_W'(g));
    msgq_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) queue_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (hit && we_i),
      .rd_i    (hit && !we_i),
      .word_i  (word),
      .wdata_i (wdata_i),
      .rdata_o (q_rdata[g]),
      .cnt_o   (q_cnt[g]),
      .ovf_o   (ovf_q[g])
    );
    assign irq_o[g] = (q_cnt[g] != '0);
  end

  always_comb begin
    stat_word = '0;
    stat_word[CNT_LSB +: CNT_FLD_W] = CNT_FLD_W'(q_cnt[qid]);
    stat_word[0] = ovf_q[qid];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (req_i && !we_i) begin
      if (data_sel)      rdata_q <= q_rdata[qid];
      else if (stat_sel) rdata_q <= stat_word;
      else               rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/msgq_mailbox_chk.sv
module msgq_mailbox_chk #(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             stat_bit_i,
  input logic [31:0]      rdata_i,
  input logic [NUM_Q-1:0] irq_i,
  input logic [NUM_Q-1:0] ovf_i
);
  for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
    // R3
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_i[g]) |-> $past(req_i && we_i))
      else $error("irq rose without a write");
    // R5
    irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_i[g]) |-> $past(req_i && !we_i))
      else $error("irq fell without a read");
    // R9
    ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[g] |=> ovf_i[g])
      else $error("overflow flag cleared");
  end

  // R4
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_i))
    else $error("read data moved without a read");

  // R7
  stat_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && stat_bit_i) |=>
      (rdata_i[23:12] <= 12'(DEPTH)) && (rdata_i[31:24] == 8'd0) && (rdata_i[11:1] == 11'd0))
    else $error("status word malformed");
endmodule

bind msgq_mailbox msgq_mailbox_chk #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .stat_bit_i (addr_i[20]),
  .rdata_i    (rdata_o),
  .irq_i      (irq_o),
  .ovf_i      (ovf_q)
);

// File: tb/msgq_mailbox_tb_top.sv
module msgq_mailbox_tb_top;
  localparam int NUM_Q = 4;
  localparam int MSG_TOTAL = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_Q-1:0] irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic rd_pending = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2ns clk = ~clk;

  msgq_mailbox #(.NUM_Q(NUM_Q), .MSG_TOTAL(MSG_TOTAL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [20:0] daddr(int p, int q, int idx);
    return 21'((p << 16) + (q << 7) + (idx << 2));
  endfunction

  function automatic logic [20:0] saddr(int q);
    return 21'((1 << 20) + (q << 2));
  endfunction

  function automatic logic [31:0] pat(int q, int m, int k);
    return 32'((q << 24) | (m << 16) | (k + 16'h5A00));
  endfunction

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [20:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1ns req = 1'b0; we = 1'b0;
  endtask

  // driver: issue read, push expected into scoreboard
  task automatic bus_read(logic [20:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1ns req = 1'b0;
  endtask

  task automatic check_irq(logic [NUM_Q-1:0] exp, string tag);
    @(negedge clk);
    check_eq(tag, 32'(irq), 32'(exp));
  endtask

  task automatic write_msg(int p, int q, int m);
    for (int k = 0; k < 16; k++) bus_write(daddr(p, q, 16 + k), pat(q, m, k));
  endtask

  task automatic read_msg(int p, int q, int m, string tag);
    for (int k = 0; k < 16; k++) bus_read(daddr(p, q, 16 + k), pat(q, m, k), tag);
  endtask

  always @(posedge clk) rd_pending <= req && !we;

  // monitor: compare read data one cycle after each read
  always @(negedge clk) begin
    if (rd_pending) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R4 unexpected read actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_eq(t, rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1ns rst_ni = 1'b1;

    // R12 reset state
    check_irq('0, "R12 irq after reset");
    check_eq("R12 rdata after reset", rdata, 32'd0);
    bus_read(saddr(0), 32'd0, "R12 status after reset");

    // R2 partial message is invisible
    for (int k = 0; k < 15; k++) bus_write(daddr(0, 0, 16 + k), pat(0, 0, k));
    check_irq('0, "R2 irq after partial");
    bus_read(saddr(0), 32'd0, "R2 count after partial");
    bus_read(daddr(0, 0, 16), 32'd0, "R2 partial not readable");

    // R3 commit
    bus_write(daddr(0, 0, 31), pat(0, 0, 15));
    check_irq(4'b0001, "R3 irq after commit");
    bus_read(saddr(0), 32'(1 << 12), "R3 R7 count one");

    // R5 middle reads do not pop; R4 words in order; R8 irq drop
    bus_read(daddr(0, 0, 17), pat(0, 0, 1), "R5 middle read a");
    bus_read(daddr(0, 0, 17), pat(0, 0, 1), "R5 middle read b");
    bus_read(saddr(0), 32'(1 << 12), "R5 count kept");
    read_msg(0, 0, 0, "R4 message words");
    check_irq('0, "R8 irq after last pop");
    bus_read(saddr(0), 32'd0, "R5 count after pop");

    // R1 requester field ignored; R6 order
    write_msg(3, 1, 1);
    write_msg(7, 1, 2);
    bus_read(saddr(1), 32'(2 << 12), "R1 R7 count two");
    check_irq(4'b0010, "R6 irq only q1");
    read_msg(0, 1, 1, "R6 first message");
    check_irq(4'b0010, "R8 irq with one left");
    read_msg(5, 1, 2, "R1 second message");
    check_irq('0, "R8 irq q1 empty");

    // R9 overflow
    write_msg(0, 2, 1);
    write_msg(0, 2, 2);
    write_msg(0, 2, 3);
    bus_read(saddr(2), 32'((2 << 12) | 1), "R9 full with overflow");
    read_msg(0, 2, 1, "R9 first kept");
    read_msg(0, 2, 2, "R9 second kept");
    bus_read(saddr(2), 32'd1, "R9 sticky flag");
    // R10 empty read
    bus_read(daddr(0, 2, 31), 32'd0, "R10 empty last read");
    bus_read(daddr(0, 2, 20), 32'd0, "R10 empty middle read");
    bus_read(saddr(2), 32'd1, "R10 count stays zero");
    check_irq('0, "R10 irq stays low");

    // R11 ignored accesses
    for (int k = 0; k < 15; k++) bus_write(daddr(0, 3, 16 + k), pat(3, 4, k));
    for (int k = 0; k < 16; k++) bus_write(daddr(0, 3, k), 32'hDEAD0000 + 32'(k));
    write_msg(0, 5, 9);
    check_irq('0, "R11 out of range queue");
    bus_read(saddr(5), 32'd0, "R11 status out of range");
    bus_read(daddr(0, 3, 3), 32'd0, "R11 low index read");
    bus_write(daddr(0, 3, 31), pat(3, 4, 15));
    // R6 independence
    write_msg(1, 0, 6);
    check_irq(4'b1001, "R6 two queues pending");
    bus_read(daddr(0, 3, 3), 32'd0, "R11 low index read pending");
    read_msg(0, 3, 4, "R11 staging not aliased");
    check_irq(4'b0001, "R6 q0 unaffected");
    bus_read(saddr(0), 32'(1 << 12), "R6 q0 count");
    read_msg(0, 0, 6, "R6 q0 message");
    check_irq('0, "R8 all empty");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule